// File: doc/BRIEF.md
# Tower-Field AES Substitution Unit

This block performs the AES byte substitution and its inverse without any lookup table. It maps each byte into a composite field, inverts it there, and maps the result back. The composite field is GF(2^4) extended by a quadratic, and the inversion is built from GF(2^4) multiplies, squares and one GF(2^4) inversion. The affine transform of the cipher and its inverse are plain XOR logic. They sit on either side of a single shared inverter, so one circuit serves both the cipher and the inverse cipher.

A mode bit arrives with every byte and travels with it through the pipeline, so the direction may change from one cycle to the next. The `PIPE` parameter sets how many register stages sit inside the unit: 0 (purely combinational), 1 (a register after the input basis change) or 2 (a further register after the GF(2^4) inversion). A valid flag follows the data with the same latency.

The isomorphism matrices are not typed in. They are derived at elaboration from a root of the AES field polynomial, found in the composite field.

Top module: `aes_cf_sbox`

## Requirements
- R1: With `in_decrypt`=0, `out_byte` equals the AES forward substitution of `in_byte`. This is the inverse modulo x^8+x^4+x^3+x+1 (0x11B, with 0 mapped to 0), followed by b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63, where bit 0 is the least significant bit.
- R2: With `in_decrypt`=1, `out_byte` equals the AES inverse substitution of `in_byte`. This is the inverse affine map rotl(s,1) ^ rotl(s,3) ^ rotl(s,6) ^ 0x05, followed by the field inverse.
- R3: Feeding any forward output back in decrypt mode returns the original byte. Internally, every nonzero composite element multiplied by its computed inverse gives 0x01.
- R4: Zero is its own inverse, so forward 0x00 gives 0x63 and inverse 0x63 gives 0x00.
- R5: `out_valid` and `out_byte` for an input appear exactly `PIPE` clock cycles after that input is presented. With `PIPE`=0 they are combinational.
- R6: With `PIPE`>=1, a synchronous reset (`rst`=1 at a rising edge) clears `out_valid`. Items in flight are discarded.
- R7: The mode is carried per item. Back-to-back items with alternating modes each get the substitution of their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is meaningful this cycle |
| in_decrypt | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | `out_byte` is meaningful |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench builds two copies of the unit side by side: one with `PIPE`=2 and one with `PIPE`=0. The registered copy exercises the two-cycle latency, the reset flush of in-flight items and the per-item mode that follows its data through both register stages. The combinational copy checks the same substitutions with no registers in the way. Both copies see all 256 bytes in each direction against tables the bench derives in GF(2^8), together with a fixed set of known values and a stream of alternating modes.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int NIBS   = BYTE_W / NIB_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    // Quadratic y^2 + y + OMEGA over GF(2^4)/(x^4+x+1); OMEGA = x^3 has trace 1
    localparam nib_t CF_OMEGA = 4'h8;
    localparam nib_t GF16_RED = 4'h3;   // x^4 = x + 1
    localparam byte_t AES_RED = 8'h1B;  // x^8 = x^4 + x^3 + x + 1

    // Item after the input basis change
    typedef struct packed {
        logic  dec;
        nib_t  hi;
        nib_t  lo;
    } cf_elem_s;

    // Item after the GF(2^4) norm inversion
    typedef struct packed {
        logic  dec;
        nib_t  hi;
        nib_t  lo;
        nib_t  dinv;
    } cf_inv_s;

    function automatic nib_t gf16_mul(nib_t a, nib_t b);
        nib_t acc;
        nib_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = {t[NIB_W-2:0], 1'b0} ^ (t[NIB_W-1] ? GF16_RED : '0);
        end
        return acc;
    endfunction

    function automatic nib_t gf16_sq(nib_t a);
        return gf16_mul(a, a);
    endfunction

    // a^14 = a^-1 for nonzero a, and 0 for a = 0
    function automatic nib_t gf16_inv(nib_t a);
        nib_t a2, a4, a8;
        a2 = gf16_sq(a);
        a4 = gf16_sq(a2);
        a8 = gf16_sq(a4);
        return gf16_mul(gf16_mul(a8, a4), a2);
    endfunction

    // Product in GF(2^4)[y]/(y^2+y+OMEGA); byte = {hi, lo} = hi*y + lo
    function automatic byte_t cf_mul(byte_t x, byte_t z);
        nib_t hh, hl, lh, ll;
        hh = gf16_mul(x[7:4], z[7:4]);
        hl = gf16_mul(x[7:4], z[3:0]);
        lh = gf16_mul(x[3:0], z[7:4]);
        ll = gf16_mul(x[3:0], z[3:0]);
        return {hh ^ hl ^ lh, gf16_mul(hh, CF_OMEGA) ^ ll};
    endfunction

    // Linear map given as eight packed columns
    function automatic byte_t map_bytes(logic [BYTE_W*BYTE_W-1:0] cols, byte_t v);
        byte_t acc;
        acc = '0;
        for (int i = 0; i < BYTE_W; i++)
            if (v[i]) acc = acc ^ cols[BYTE_W*i +: BYTE_W];
        return acc;
    endfunction

    // Columns of the basis change: x^i maps to beta^i, beta a composite root of 0x11B
    function automatic logic [BYTE_W*BYTE_W-1:0] build_sigma_cols();
        logic [BYTE_W*(BYTE_W+1)-1:0] pw;
        logic [BYTE_W*BYTE_W-1:0]     cols;
        logic                         found;
        byte_t                        poly;
        cols  = '0;
        found = 1'b0;
        for (int c = 2; c < 256; c++) begin
            pw = '0;
            pw[BYTE_W-1:0] = 8'h01;
            for (int i = 1; i <= BYTE_W; i++)
                pw[BYTE_W*i +: BYTE_W] = cf_mul(pw[BYTE_W*(i-1) +: BYTE_W], byte_t'(c));
            poly = pw[64 +: 8] ^ pw[32 +: 8] ^ pw[24 +: 8] ^ pw[8 +: 8] ^ pw[0 +: 8];
            if (!found && poly == 8'h00) begin
                found = 1'b1;
                cols  = pw[BYTE_W*BYTE_W-1:0];
            end
        end
        return cols;
    endfunction

    // Columns of the reverse map, found by searching the forward map
    function automatic logic [BYTE_W*BYTE_W-1:0] build_sigma_inv_cols(
        logic [BYTE_W*BYTE_W-1:0] fwd
    );
        logic [BYTE_W*BYTE_W-1:0] cols;
        cols = '0;
        for (int j = 0; j < BYTE_W; j++)
            for (int c = 0; c < 256; c++)
                if (map_bytes(fwd, byte_t'(c)) == (byte_t'(1) << j))
                    cols[BYTE_W*j +: BYTE_W] = byte_t'(c);
        return cols;
    endfunction

    localparam logic [BYTE_W*BYTE_W-1:0] SIGMA_COLS     = build_sigma_cols();
    localparam logic [BYTE_W*BYTE_W-1:0] SIGMA_INV_COLS = build_sigma_inv_cols(SIGMA_COLS);

    function automatic byte_t rotl8(byte_t b, int k);
        return byte_t'((b << k) | (b >> (BYTE_W - k)));
    endfunction

    function automatic byte_t affine_fwd(byte_t b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic byte_t affine_inv(byte_t s);
        return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
    endfunction

endpackage

// File: rtl/aes_cf_stage_reg.sv
module aes_cf_stage_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vin,
    input  logic [W-1:0] din,
    output logic         vout,
    output logic [W-1:0] dout
);
    generate
        if (EN) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    vout <= 1'b0;
                    dout <= '0;
                end else begin
                    vout <= vin;
                    dout <= din;
                end
            end
        end else begin : g_wire
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign vout = vin;
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/aes_cf_affine.sv
module aes_cf_affine
    import aes_cf_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  byte_t din,
    input  logic  apply,
    output byte_t dout
);
    byte_t mapped;
    generate
        if (INVERSE) begin : g_inv
            assign mapped = affine_inv(din);
        end else begin : g_fwd
            assign mapped = affine_fwd(din);
        end
    endgenerate
    assign dout = apply ? mapped : din;
endmodule

// File: rtl/aes_cf_basis.sv
module aes_cf_basis
    import aes_cf_pkg::*;
#(
    parameter bit TO_COMPOSITE = 1'b1
) (
    input  byte_t din,
    output byte_t dout
);
    localparam logic [BYTE_W*BYTE_W-1:0] COLS =
        TO_COMPOSITE ? SIGMA_COLS : SIGMA_INV_COLS;

    // One XOR tree per output bit, selected by the column bits
    generate
        for (genvar r = 0; r < BYTE_W; r++) begin : g_row
            logic [BYTE_W-1:0] row_mask;
            for (genvar c = 0; c < BYTE_W; c++) begin : g_col
                assign row_mask[c] = COLS[BYTE_W*c + r];
            end
            assign dout[r] = ^(row_mask & din);
        end
    endgenerate
endmodule

// File: rtl/aes_cf_norm_inv.sv
module aes_cf_norm_inv
    import aes_cf_pkg::*;
(
    input  nib_t hi,
    input  nib_t lo,
    output nib_t dinv
);
    nib_t norm;
    // hi^2*OMEGA + hi*lo + lo^2 (psi = 1)
    always_comb begin
        norm = gf16_mul(gf16_sq(hi), CF_OMEGA) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
        dinv = gf16_inv(norm);
    end
endmodule

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox
    import aes_cf_pkg::*;
#(
    parameter int PIPE = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_decrypt,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    localparam bit REG_A = (PIPE >= 1);
    localparam bit REG_B = (PIPE >= 2);
    localparam int W_A   = $bits(cf_elem_s);
    localparam int W_B   = $bits(cf_inv_s);

    // Stage 0: optional inverse affine, then into the composite basis
    byte_t    pre_byte;
    byte_t    cf0;
    cf_elem_s s0, s1;
    logic     v1;

    aes_cf_affine #(.INVERSE(1'b1)) u_pre (
        .din(in_byte), .apply(in_decrypt), .dout(pre_byte)
    );
    aes_cf_basis #(.TO_COMPOSITE(1'b1)) u_to_cf (
        .din(pre_byte), .dout(cf0)
    );

    assign s0 = '{dec: in_decrypt, hi: cf0[7:4], lo: cf0[3:0]};

    aes_cf_stage_reg #(.W(W_A), .EN(REG_A)) u_reg_a (
        .clk(clk), .rst(rst), .vin(in_valid), .din(s0), .vout(v1), .dout(s1)
    );

    // Stage 1: norm and its GF(2^4) inverse
    nib_t    dinv1;
    cf_inv_s t1, s2;
    logic    v2;

    aes_cf_norm_inv u_norm_inv (.hi(s1.hi), .lo(s1.lo), .dinv(dinv1));

    assign t1 = '{dec: s1.dec, hi: s1.hi, lo: s1.lo, dinv: dinv1};

    aes_cf_stage_reg #(.W(W_B), .EN(REG_B)) u_reg_b (
        .clk(clk), .rst(rst), .vin(v1), .din(t1), .vout(v2), .dout(s2)
    );

    // Stage 2: finish the composite inverse, back to the AES basis, affine
    byte_t inv_cf;
    byte_t back_byte;

    always_comb begin
        inv_cf[7:4] = gf16_mul(s2.hi, s2.dinv);
        inv_cf[3:0] = gf16_mul(s2.hi ^ s2.lo, s2.dinv);
    end

    aes_cf_basis #(.TO_COMPOSITE(1'b0)) u_from_cf (
        .din(inv_cf), .dout(back_byte)
    );
    aes_cf_affine #(.INVERSE(1'b0)) u_post (
        .din(back_byte), .apply(!s2.dec), .dout(out_byte)
    );

    assign out_valid = v2;

    // R3: the shared inverter yields a true inverse for any nonzero element
    a_r3_inverse_product: assert property (@(posedge clk) disable iff (rst)
        (v2 && {s2.hi, s2.lo} != 8'h00) |-> (cf_mul({s2.hi, s2.lo}, inv_cf) == 8'h01));

    // R4: zero passes the inverter as zero
    a_r4_zero_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (v2 && {s2.hi, s2.lo} == 8'h00) |-> (inv_cf == 8'h00));

    // R3: the two basis maps undo each other on the live input
    a_r3_basis_roundtrip: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (map_bytes(SIGMA_INV_COLS, cf0) == pre_byte));

    // R5 and R6: latency of the valid flag and reset flush
    generate
        if (PIPE == 0) begin : g_chk0
            a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid);
        end else if (PIPE == 1) begin : g_chk1
            a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (out_valid == $past(in_valid)));
            a_r6_reset_flush: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !out_valid);
        end else begin : g_chk2
            a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));
            a_r6_reset_flush: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !out_valid);
        end
    endgenerate

endmodule

// File: tb/aes_cf_sbox_tb.sv
module aes_cf_sbox_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_decrypt;
    logic [7:0] in_byte;
    logic       out_valid,  out_valid_p0;
    logic [7:0] out_byte,   out_byte_p0;

    always #5 clk = ~clk;

    aes_cf_sbox #(.PIPE(2)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_decrypt(in_decrypt),
        .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte)
    );

    aes_cf_sbox #(.PIPE(0)) u_dut_p0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_decrypt(in_decrypt),
        .in_byte(in_byte), .out_valid(out_valid_p0), .out_byte(out_byte_p0)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] s_tbl [256];
    logic [7:0] i_tbl [256];

    // Known vectors {decrypt, input, expected}
    localparam logic [16:0] VECS [0:14] = '{
        {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7c}, {1'b0, 8'h02, 8'h77},
        {1'b0, 8'h03, 8'h7b}, {1'b0, 8'h53, 8'hed}, {1'b0, 8'hff, 8'h16},
        {1'b0, 8'h10, 8'hca}, {1'b0, 8'h52, 8'h00}, {1'b0, 8'h09, 8'h01},
        {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7c, 8'h01}, {1'b1, 8'hed, 8'h53},
        {1'b1, 8'h16, 8'hff}, {1'b1, 8'h00, 8'h52}, {1'b1, 8'h01, 8'h09}
    };

    function automatic logic [7:0] xt(logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] t   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = xt(t);
        end
        return acc;
    endfunction

    function automatic logic [7:0] ginv(logic [7:0] a);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < 254; i++) r = gmul(r, a);
        return r;
    endfunction

    function automatic logic [7:0] rl(logic [7:0] b, int k);
        return (b << k) | (b >> (8 - k));
    endfunction

    // Scoreboard for the two-stage copy
    logic       qv   [2];
    logic [7:0] qexp [2];
    string      qtag [2];

    task automatic report(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic clear_q();
        for (int i = 0; i < 2; i++) begin
            qv[i] = 1'b0; qexp[i] = 8'h00; qtag[i] = "";
        end
    endtask

    task automatic step(logic v, logic dec, logic [7:0] d, logic [7:0] exp, string tag);
        @(negedge clk);
        report("R5 valid latency", {7'd0, out_valid}, {7'd0, qv[1]});
        if (qv[1]) report({qtag[1], " piped"}, out_byte, qexp[1]);
        qv[1] = qv[0]; qexp[1] = qexp[0]; qtag[1] = qtag[0];
        qv[0] = v;     qexp[0] = exp;     qtag[0] = tag;
        in_valid = v; in_decrypt = dec; in_byte = d;
        #1;
        report("R5 comb valid", {7'd0, out_valid_p0}, {7'd0, v});
        if (v) report({tag, " comb"}, out_byte_p0, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 8'h00, "idle");
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] b;
            logic [7:0] s;
            b = (x == 0) ? 8'h00 : ginv(8'(x));
            s = b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
            s_tbl[x] = s;
            i_tbl[s] = 8'(x);
        end
        clear_q();
        rst = 1'b1; in_valid = 1'b0; in_decrypt = 1'b0; in_byte = 8'h00;
        repeat (3) @(negedge clk);
        report("R6 reset valid", {7'd0, out_valid}, 8'h00);
        rst = 1'b0;

        // Known vectors (R1, R2, R4)
        for (int k = 0; k < 15; k++)
            step(1'b1, VECS[k][16], VECS[k][15:8], VECS[k][7:0],
                 VECS[k][16] ? "R2 vector" : "R1 vector");
        idle(2);

        // R4: zero corner in both directions
        step(1'b1, 1'b0, 8'h00, 8'h63, "R4 fwd zero");
        step(1'b1, 1'b1, 8'h63, 8'h00, "R4 inv zero");
        idle(2);

        // R1: every byte forward
        for (int x = 0; x < 256; x++) step(1'b1, 1'b0, 8'(x), s_tbl[x], "R1 sweep");
        // R2: every byte inverse
        for (int x = 0; x < 256; x++) step(1'b1, 1'b1, 8'(x), i_tbl[x], "R2 sweep");
        // R3: forward outputs fed back give the original byte
        for (int x = 0; x < 256; x += 3) step(1'b1, 1'b1, s_tbl[x], 8'(x), "R3 roundtrip");
        idle(2);

        // R7: alternating modes every cycle
        for (int k = 0; k < 64; k++) begin
            logic [7:0] d;
            d = 8'(k * 37 + 11);
            if (k % 2 == 0) step(1'b1, 1'b0, d, s_tbl[d], "R7 alt fwd");
            else            step(1'b1, 1'b1, d, i_tbl[d], "R7 alt inv");
        end
        idle(2);

        // R5: single item, valid must appear exactly two cycles later
        step(1'b1, 1'b0, 8'h53, 8'hed, "R5 single");
        idle(3);

        // R6: reset while items are in flight discards them
        step(1'b1, 1'b0, 8'h01, 8'h7c, "R6 pre");
        step(1'b1, 1'b0, 8'h02, 8'h77, "R6 pre");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        report("R6 flush valid", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        report("R6 flush valid 2", {7'd0, out_valid}, 8'h00);
        rst = 1'b0;
        clear_q();
        idle(3);
        step(1'b1, 1'b1, 8'h16, 8'hff, "R6 after reset");
        idle(3);

        finish_run();
    end

endmodule